// File: doc/BRIEF.md
# Channel Repeater with Per-Connection Coded Drivers

This block models one programmable repeater sitting on a routing-channel boundary. The repeater has two sides: side A (left or top) and side B (right or bottom). Each side touches one sector wire and one global wire, so the repeater has four connections. Each connection has its own driver, and a 3-bit code controls it. The code either switches the driver off or names its source relative to the repeater. The source can be the far side's global wire, the far side's sector wire, or the other wire on the same side. For every connection the block reports whether it is driving the wire and what value it drives.

Codes are loaded by octet writes that carry an X, Y, Z address and a D data octet. A repeater instance answers only to writes that carry all of the following:
- its own X and Y position;
- a Z octet whose top bits mark a repeater resource;
- an orientation bit that matches its channel;
- its own lane number.

The lowest Z bit picks the side. One D octet holds both codes for that side. Its two top bits are clock-sector settings, which the repeater only stores and presents on an output.

Each connection holds an enumerated driver state, with four values:
- `DRV_OFF`
- `DRV_FAR_GLB`
- `DRV_FAR_SEC`
- `DRV_SAME_SIDE`

The state changes in these cases:
- Reset moves every connection to `DRV_OFF`.
- A matching write moves a connection to the state its new code decodes to. The transition names are *load-off*, *load-far-global*, *load-far-sector* and *load-same-side*.
- With no matching write, a connection keeps its state (*hold*).

A guard prevents loops through the repeater. A driver stays off while its chosen source connection is itself configured to be driven.

Top module: `rpt_repeater`

## Requirements
- R1: Connections are indexed 0 = side-A sector, 1 = side-A global, 2 = side-B sector, 3 = side-B global; bit i of `drv_en`/`drv_val` belongs to connection i, and a connection whose driver is off shows `drv_en` low and `drv_val` low.
- R2: Code 3'b000 puts the connection's driver in `DRV_OFF`.
- R3: Code 3'b100 drives the connection from the global wire on the opposite side (`drv_val` equals that wire's `wire_in` bit).
- R4: Code 3'b010 drives the connection from the sector wire on the opposite side.
- R5: Code 3'b001 drives the connection from the other wire on its own side (sector from global, global from sector).
- R6: Any nonzero code that is not one-hot (3'b011, 3'b101, 3'b110, 3'b111) is treated as `DRV_OFF`.
- R7: A write takes effect only when `wr_en` is high, `wr_x`/`wr_y` equal the instance position, `wr_z[7:5]` is 3'b001, `wr_z[4]` equals the orientation parameter (0 horizontal, 1 vertical) and `wr_z[3:1]` equals 4 minus the lane parameter; `wr_z[0]` selects side A (0) or side B (1). Any other write changes nothing.
- R8: In the D octet, bits [2:0] are the sector-wire code, bits [5:3] the global-wire code, and bits [7:6] are stored and shown on `aux_bits` as {side B [7:6], side A [7:6]}.
- R9: A driver whose selected source connection is configured in a state other than `DRV_OFF` keeps `drv_en` low, so no two connections ever drive each other.
- R10: Reset clears all codes and `aux_bits`. A write is visible on the outputs after the clock edge that accepts it; before that edge the outputs follow the previous configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Configuration write strobe |
| wr_x | input | 8 | Write address, X octet |
| wr_y | input | 8 | Write address, Y octet |
| wr_z | input | 8 | Write address, Z octet (resource type, orientation, lane, side) |
| wr_d | input | 8 | Write data octet |
| wire_in | input | 4 | Value sensed on each of the four connections |
| drv_val | output | 4 | Value each connection's driver puts on its wire |
| drv_en | output | 4 | Drive enable per connection |
| aux_bits | output | 4 | Stored clock-sector bits, {B[7:6], A[7:6]} |

## Verification
A configuration write and a change on a source wire can occur in the same cycle. The bench provokes this by raising the source wire and writing an off code to the driven connection on the same negative edge. Before the next rising edge, the driven output must already carry the new wire value under the old state. After that edge, the driver must be off. A second overlap comes from a single write that makes one connection driven: the same write must disable another driver whose source is that connection. The vector table includes both mutual-reference and chain cases.

// File: rtl/rpt_pkg.sv
package rpt_pkg;
    localparam int NUM_CONN = 4;
    localparam int CODE_W   = 3;
    localparam int AUX_W    = 2;
    localparam int IDX_W    = $clog2(NUM_CONN);

    typedef enum logic [1:0] {
        DRV_OFF       = 2'd0,
        DRV_FAR_GLB   = 2'd1,
        DRV_FAR_SEC   = 2'd2,
        DRV_SAME_SIDE = 2'd3
    } drv_mode_e;

    function automatic drv_mode_e decode_code(input logic [CODE_W-1:0] code);
        drv_mode_e m;
        case (code)
            3'b100:  m = DRV_FAR_GLB;
            3'b010:  m = DRV_FAR_SEC;
            3'b001:  m = DRV_SAME_SIDE;
            default: m = DRV_OFF;
        endcase
        return m;
    endfunction
endpackage

// File: rtl/rpt_cfg_port.sv
module rpt_cfg_port
    import rpt_pkg::*;
#(
    parameter int OCT_W    = 8,
    parameter int X_POS    = 3,
    parameter int Y_POS    = 5,
    parameter int VERTICAL = 0,
    parameter int LANE     = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [OCT_W-1:0]     wr_x,
    input  logic [OCT_W-1:0]     wr_y,
    input  logic [OCT_W-1:0]     wr_z,
    input  logic [OCT_W-1:0]     wr_d,
    output logic                 load_a,
    output logic                 load_b,
    output logic [2*AUX_W-1:0]   aux_q
);
    localparam logic [2:0] KIND_TAG  = 3'b001;
    localparam logic       ORIENT    = (VERTICAL != 0);
    localparam logic [2:0] LANE_CODE = 3'(4 - LANE);

    logic hit;

    always_comb begin
        hit = wr_en
              && (wr_x == OCT_W'(X_POS))
              && (wr_y == OCT_W'(Y_POS))
              && (wr_z[7:5] == KIND_TAG)
              && (wr_z[4] == ORIENT)
              && (wr_z[3:1] == LANE_CODE);
        load_a = hit && !wr_z[0];
        load_b = hit &&  wr_z[0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            aux_q <= '0;
        end else if (load_a) begin
            aux_q[AUX_W-1:0] <= wr_d[OCT_W-1:OCT_W-AUX_W];
        end else if (load_b) begin
            aux_q[2*AUX_W-1:AUX_W] <= wr_d[OCT_W-1:OCT_W-AUX_W];
        end
    end

    assert_ignore_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> $stable(aux_q));
endmodule

// File: rtl/rpt_drv_slot.sv
module rpt_drv_slot
    import rpt_pkg::*;
#(
    parameter int SIDE = 0,
    parameter int KIND = 0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [CODE_W-1:0]   code,
    input  logic [NUM_CONN-1:0] wire_in,
    input  logic [NUM_CONN-1:0] cfg_on_vec,
    output logic                cfg_on,
    output logic                drv_en,
    output logic                drv_val
);
    localparam logic [IDX_W-1:0] SRC_SAME    = IDX_W'(SIDE * 2 + (1 - KIND));
    localparam logic [IDX_W-1:0] SRC_FAR_SEC = IDX_W'((1 - SIDE) * 2);
    localparam logic [IDX_W-1:0] SRC_FAR_GLB = IDX_W'((1 - SIDE) * 2 + 1);

    drv_mode_e          mode_q;
    logic [IDX_W-1:0]   src_idx;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= DRV_OFF;
        end else if (load) begin
            mode_q <= decode_code(code);
        end
    end

    // outputs
    always_comb begin
        src_idx = SRC_SAME;
        cfg_on  = 1'b0;
        unique case (mode_q)
            DRV_OFF:       begin src_idx = SRC_SAME;    cfg_on = 1'b0; end
            DRV_FAR_GLB:   begin src_idx = SRC_FAR_GLB; cfg_on = 1'b1; end
            DRV_FAR_SEC:   begin src_idx = SRC_FAR_SEC; cfg_on = 1'b1; end
            DRV_SAME_SIDE: begin src_idx = SRC_SAME;    cfg_on = 1'b1; end
        endcase
        drv_en  = cfg_on && !cfg_on_vec[src_idx];
        drv_val = drv_en && wire_in[src_idx];
    end

    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(mode_q));
    assert_off_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (load && code == 3'b000) |=> (mode_q == DRV_OFF));
    assert_far_glb_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (load && code == 3'b100) |=> (mode_q == DRV_FAR_GLB));
    assert_bad_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !$onehot0(code)) |=> (mode_q == DRV_OFF));
endmodule

// File: rtl/rpt_repeater.sv
module rpt_repeater
    import rpt_pkg::*;
#(
    parameter int OCT_W    = 8,
    parameter int X_POS    = 3,
    parameter int Y_POS    = 5,
    parameter int VERTICAL = 0,
    parameter int LANE     = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [OCT_W-1:0]      wr_x,
    input  logic [OCT_W-1:0]      wr_y,
    input  logic [OCT_W-1:0]      wr_z,
    input  logic [OCT_W-1:0]      wr_d,
    input  logic [NUM_CONN-1:0]   wire_in,
    output logic [NUM_CONN-1:0]   drv_val,
    output logic [NUM_CONN-1:0]   drv_en,
    output logic [2*AUX_W-1:0]    aux_bits
);
    logic                load_a;
    logic                load_b;
    logic [NUM_CONN-1:0] cfg_on_vec;

    rpt_cfg_port #(
        .OCT_W(OCT_W), .X_POS(X_POS), .Y_POS(Y_POS),
        .VERTICAL(VERTICAL), .LANE(LANE)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
        .wr_x(wr_x), .wr_y(wr_y), .wr_z(wr_z), .wr_d(wr_d),
        .load_a(load_a), .load_b(load_b), .aux_q(aux_bits)
    );

    for (genvar i = 0; i < NUM_CONN; i++) begin : g_slot
        localparam int SIDE = i / 2;
        localparam int KIND = i % 2;
        logic              slot_load;
        logic [CODE_W-1:0] slot_code;

        if (SIDE == 0) begin : g_sa
            assign slot_load = load_a;
        end else begin : g_sb
            assign slot_load = load_b;
        end
        if (KIND == 0) begin : g_sec
            assign slot_code = wr_d[CODE_W-1:0];
        end else begin : g_glb
            assign slot_code = wr_d[2*CODE_W-1:CODE_W];
        end

        rpt_drv_slot #(.SIDE(SIDE), .KIND(KIND)) u_slot (
            .clk(clk), .rst_n(rst_n),
            .load(slot_load), .code(slot_code),
            .wire_in(wire_in), .cfg_on_vec(cfg_on_vec),
            .cfg_on(cfg_on_vec[i]),
            .drv_en(drv_en[i]), .drv_val(drv_val[i])
        );
    end

    assert_guard_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_en & ~cfg_on_vec) == '0);
    assert_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_val & ~drv_en) == '0);
endmodule

// File: tb/tb_rpt_repeater.sv
module tb_rpt_repeater;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_x = 8'd3, wr_y = 8'd5, wr_z = 8'h00, wr_d = 8'h00;
    logic [3:0] wire_in = 4'h0;
    logic [3:0] drv_val, drv_en, aux_bits;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    rpt_repeater dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
        .wr_x(wr_x), .wr_y(wr_y), .wr_z(wr_z), .wr_d(wr_d),
        .wire_in(wire_in), .drv_val(drv_val), .drv_en(drv_en),
        .aux_bits(aux_bits)
    );

    // {z, d, wire_in, exp_en, exp_val}; address X=3 Y=5, lane 2 horizontal: side A z=8'h24, side B z=8'h25
    localparam int NV = 9;
    localparam logic [27:0] VEC [0:NV-1] = '{
        {8'h24, 8'b00_000_010, 4'b0100, 4'b0001, 4'b0001}, // R4 A sector from far sector
        {8'h24, 8'b00_000_010, 4'b0000, 4'b0001, 4'b0000}, // R4 follows source low
        {8'h25, 8'b00_001_000, 4'b0100, 4'b1001, 4'b1001}, // R5 B global from B sector
        {8'h25, 8'b00_000_010, 4'b1111, 4'b0000, 4'b0000}, // R9 mutual reference
        {8'h24, 8'b00_100_000, 4'b1001, 4'b0110, 4'b0110}, // R3 A global from far global, R2
        {8'h24, 8'b00_110_011, 4'b0001, 4'b0100, 4'b0100}, // R6 invalid codes
        {8'h25, 8'b00_100_001, 4'b0010, 4'b1000, 4'b1000}, // R9 chain, R3
        {8'h34, 8'b00_000_000, 4'b0010, 4'b1000, 4'b1000}, // R7 wrong orientation
        {8'h26, 8'b00_000_000, 4'b0000, 4'b1000, 4'b0000}  // R7 wrong lane
    };

    task automatic check4(input string tag, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic write_oct(input logic [7:0] x, input logic [7:0] z, input logic [7:0] d, input logic en);
        @(negedge clk);
        wr_x = x; wr_z = z; wr_d = d; wr_en = en;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #2;
        check4("R10 reset en", drv_en, 4'b0000);
        check4("R1 reset val", drv_val, 4'b0000);
        check4("R10 reset aux", aux_bits, 4'b0000);
        @(negedge clk);
        rst_n = 1'b1;

        for (int k = 0; k < NV; k++) begin
            write_oct(8'd3, VEC[k][27:20], VEC[k][19:12], 1'b1);
            wire_in = VEC[k][11:8];
            #2;
            check4($sformatf("R1 vec%0d en", k), drv_en, VEC[k][7:4]);
            check4($sformatf("R1 vec%0d val", k), drv_val, VEC[k][3:0]);
        end

        // R7: wrong X ignored (would enable A global)
        write_oct(8'd4, 8'h24, 8'b00_001_000, 1'b1);
        #2 check4("R7 wrong X", drv_en, 4'b1000);
        // R7: strobe low ignored
        write_oct(8'd3, 8'h24, 8'b00_001_000, 1'b0);
        #2 check4("R7 wr_en low", drv_en, 4'b1000);

        // R10: write and source change in the same cycle
        @(negedge clk);
        wire_in = 4'b0010;
        wr_x = 8'd3; wr_z = 8'h25; wr_d = 8'h00; wr_en = 1'b1;
        #2 check4("R10 before edge val", drv_val, 4'b1000);
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        #2 check4("R10 after edge en", drv_en, 4'b0000);

        // R8: aux bits per side
        write_oct(8'd3, 8'h24, 8'b10_000_000, 1'b1);
        #2 check4("R8 aux A", aux_bits, 4'b0010);
        write_oct(8'd3, 8'h25, 8'b01_000_001, 1'b1);
        #2 check4("R8 aux B", aux_bits, 4'b0110);
        // R8: B sector code field in [2:0] -> from B global (undriven)
        wire_in = 4'b1000;
        #2 check4("R8 sector field", drv_val, 4'b0100);

        // R10: reset clears
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        #2;
        check4("R10 reset clears en", drv_en, 4'b0000);
        check4("R10 reset clears aux", aux_bits, 4'b0000);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (2000) @(posedge clk);
                checks++;
                failures++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule